// File: doc/BRIEF.md
# Dual-Mode Serial Port

This block is a byte-wide serial port with two operating modes. In the synchronous shift mode the port generates the shift clock on its `txd` pin. A single bidirectional data line, split here into `rxd_in`, `rxd_out` and `rxd_oe`, carries bytes out to or in from the far end. In the asynchronous mode `txd` and `rxd_in` are a plain UART pair, timed by an external timer overflow pulse on `baud_tick`.

Software reaches the port through two registers selected by `reg_sel`. Register 0 is the control register. Register 1 is the data buffer. Writing the buffer starts a transmission, and reading it returns the most recent accepted receive byte. Completion of a transmit or a receive raises a sticky done flag. The flags are brought out on `tx_done` and `rx_done`, and only a software write to the control register lowers them.

Control register layout (`reg_sel` = 0):
- bit 0: mode; 0 is the shift mode, 1 is the UART mode.
- bit 1: receive enable.
- bit 2: rate select; 1 gives 16 ticks per bit, 0 gives 32 ticks per bit.
- bits 5:3: always read 0.
- bit 6: transmit-done flag.
- bit 7: receive-done flag.

Writes replace every field, including both flags.

Top module: `dmsp_top`

## Requirements
- R1: After reset the control register and the data buffer read 0, `txd` is 1 and `rxd_oe` is 0.
- R2: In shift mode, writing the buffer sends its 8 bits LSB first on `rxd_out` with `rxd_oe` high. Each bit lasts 12 clocks, during which `txd` is low for 6 clocks and then high for 6. At the end, `tx_done` (control bit 6) is set and `rxd_oe` returns to 0.
- R3: In shift mode with receive enable at 1 and the receive-done flag at 0, the port clocks in 8 bits LSB first from `rxd_in`, each sampled at a rising edge of `txd`. It then sets control bit 7 and stores the byte in the buffer. No further `txd` clock runs while bit 7 stays 1.
- R4: In UART mode a transmitted frame is a 0 start bit, 8 data bits LSB first, and a 1 stop bit.
- R5: The UART bit time is 16 `baud_tick` pulses when control bit 2 is 1 and 32 pulses when it is 0.
- R6: Both done flags are set only by completions and stay set until software writes the control register.
- R7: With receive enable at 1 in UART mode, a valid frame on `rxd_in` sets control bit 7 and places its data byte in the buffer.
- R8: A low pulse on `rxd_in` shorter than half a bit time does not start a frame and leaves control bit 7 at 0.
- R9: A UART frame that completes while control bit 7 is 1 is discarded, and the buffer keeps its earlier byte.
- R10: Transmit data is held apart from receive data, so a buffer write never changes the value that a buffer read returns.
- R11: In UART mode a buffer write during an ongoing transmission is ignored and produces no second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle timer overflow pulse for UART timing |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 data buffer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| rxd_in | input | 1 | Receive line / shift-mode data input |
| rxd_out | output | 1 | Shift-mode data output |
| rxd_oe | output | 1 | Shift-mode data output enable |
| txd | output | 1 | UART transmit line / shift-mode clock |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |

## Verification
Shift-mode transfers use the patterns 0xA5, 0x3C and 0x69. Their alternating and grouped bits expose bit-order reversal and any slip in the data clock phase. A UART byte of all ones leaves only the start bit low, which isolates one bit time so that the two rate settings can be told apart by their length. Receive tests send 0xC3, then 0x18 while the receive flag is still set, then 0x7E and 0x96. These separate correct capture from wrongful overwrite and confirm the 32-tick rate. A short low glitch followed by a genuine frame distinguishes majority-voted start detection from a plain edge trigger.

// File: rtl/dmsp_pkg.sv
package dmsp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_UART  = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic       rx_flag;
        logic       tx_flag;
        logic [2:0] spare;
        logic       fast;
        logic       rx_on;
        port_mode_e mode;
    } ctrl_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_TX,
        SH_RX
    } shift_st_e;

    typedef enum logic [1:0] {
        UR_IDLE,
        UR_START,
        UR_DATA,
        UR_STOP
    } urx_st_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/dmsp_shift_eng.sv
module dmsp_shift_eng
    import dmsp_pkg::*;
#(
    parameter int DW  = 8,
    parameter int DIV = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tx_req,
    input  logic [DW-1:0] tx_byte,
    input  logic          rx_allow,
    input  logic          din,
    output logic          shclk,
    output logic          dout,
    output logic          doe,
    output logic          tx_end,
    output logic          rx_end,
    output logic [DW-1:0] rx_byte
);
    localparam int PW   = $clog2(DIV);
    localparam int BW   = $clog2(DW);
    localparam int HALF = DIV / 2;

    shift_st_e     st;
    logic [PW-1:0] ph;
    logic [BW-1:0] bitn;
    logic [DW-1:0] sh;
    logic          pend;
    logic [DW-1:0] pend_byte;
    logic          last_ph;
    logic          last_bit;

    assign last_ph  = (ph == PW'(DIV - 1));
    assign last_bit = (bitn == BW'(DW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SH_IDLE;
            ph        <= '0;
            bitn      <= '0;
            sh        <= '0;
            pend      <= 1'b0;
            pend_byte <= '0;
        end else begin
            if (tx_req && !pend && st != SH_TX) begin
                pend      <= 1'b1;
                pend_byte <= tx_byte;
            end
            case (st)
                SH_IDLE: begin
                    if (active && pend) begin
                        st   <= SH_TX;
                        sh   <= pend_byte;
                        ph   <= '0;
                        bitn <= '0;
                        pend <= 1'b0;
                    end else if (active && rx_allow) begin
                        st   <= SH_RX;
                        ph   <= '0;
                        bitn <= '0;
                    end
                end
                default: begin
                    if (!active) begin
                        st <= SH_IDLE;
                    end else begin
                        if (st == SH_RX && ph == PW'(HALF - 1))
                            sh <= {din, sh[DW-1:1]};
                        if (last_ph) begin
                            ph <= '0;
                            if (st == SH_TX)
                                sh <= {1'b0, sh[DW-1:1]};
                            if (last_bit)
                                st <= SH_IDLE;
                            else
                                bitn <= bitn + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign shclk   = (st == SH_IDLE) ? 1'b1 : (ph >= PW'(HALF));
    assign dout    = (st == SH_TX) ? sh[0] : 1'b1;
    assign doe     = (st == SH_TX);
    assign tx_end  = active && (st == SH_TX) && last_ph && last_bit;
    assign rx_end  = active && (st == SH_RX) && last_ph && last_bit;
    assign rx_byte = sh;

endmodule

// File: rtl/dmsp_uart_tx.sv
module dmsp_uart_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          stb,
    input  logic          load,
    input  logic [DW-1:0] data,
    output logic          line,
    output logic          done
);
    localparam int FW = DW + 2;
    localparam int CW = $clog2(OVS);
    localparam int NW = $clog2(FW);

    logic          busy;
    logic [FW-1:0] fr;
    logic [CW-1:0] cnt;
    logic [NW-1:0] bitn;
    logic          bit_end;

    assign bit_end = stb && (cnt == CW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            fr   <= '1;
            cnt  <= '0;
            bitn <= '0;
        end else if (!active) begin
            busy <= 1'b0;
        end else if (!busy) begin
            if (load) begin
                fr   <= {1'b1, data, 1'b0};
                busy <= 1'b1;
                cnt  <= '0;
                bitn <= '0;
            end
        end else if (stb) begin
            if (bit_end) begin
                cnt <= '0;
                fr  <= {1'b1, fr[FW-1:1]};
                if (bitn == NW'(FW - 1))
                    busy <= 1'b0;
                else
                    bitn <= bitn + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign line = busy ? fr[0] : 1'b1;
    assign done = active && busy && bit_end && (bitn == NW'(FW - 1));

endmodule

// File: rtl/dmsp_uart_rx.sv
module dmsp_uart_rx
    import dmsp_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          stb,
    input  logic          din,
    output logic          got,
    output logic [DW-1:0] byte_o
);
    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(DW);
    localparam int MID = OVS / 2;

    urx_st_e       st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [1:0]    vt;
    logic [DW-1:0] sh;
    logic          m;
    logic          decide;

    assign m      = vote3(vt[0], vt[1], din);
    assign decide = stb && (cnt == CW'(MID + 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= UR_IDLE;
            cnt  <= '0;
            bitn <= '0;
            vt   <= '0;
            sh   <= '0;
        end else if (!active) begin
            st <= UR_IDLE;
        end else begin
            case (st)
                UR_IDLE: begin
                    if (!din) begin
                        st  <= UR_START;
                        cnt <= '0;
                    end
                end
                default: begin
                    if (stb) begin
                        if (cnt == CW'(MID - 1)) vt[0] <= din;
                        if (cnt == CW'(MID))     vt[1] <= din;
                        if (decide) begin
                            case (st)
                                UR_START: if (m) st <= UR_IDLE;
                                UR_DATA:  sh <= {m, sh[DW-1:1]};
                                UR_STOP:  st <= UR_IDLE;
                                default:  ;
                            endcase
                        end
                        if (cnt == CW'(OVS - 1)) begin
                            cnt <= '0;
                            if (st == UR_START) begin
                                st   <= UR_DATA;
                                bitn <= '0;
                            end else if (st == UR_DATA) begin
                                if (bitn == BW'(DW - 1))
                                    st <= UR_STOP;
                                else
                                    bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign got    = active && decide && (st == UR_STOP) && m;
    assign byte_o = sh;

endmodule

// File: rtl/dmsp_top.sv
module dmsp_top
    import dmsp_pkg::*;
#(
    parameter int DW       = BYTE_W,
    parameter int SYNC_DIV = 12,
    parameter int OVS      = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          rxd_in,
    output logic          rxd_out,
    output logic          rxd_oe,
    output logic          txd,
    output logic          tx_done,
    output logic          rx_done
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] rx_buf_q;
    logic [1:0]    rx_meta;
    logic          pre;
    logic          stb;
    logic          is_uart;
    logic          ctrl_wr;
    logic          buf_wr;

    logic          sh_clk, sh_dout, sh_doe, sh_tx_end, sh_rx_end;
    logic [DW-1:0] sh_byte;
    logic          u_line, u_tx_done, u_got;
    logic [DW-1:0] u_byte;
    logic          rx_store;

    assign is_uart = (ctrl_q.mode == MODE_UART);
    assign ctrl_wr = reg_wr && !reg_sel;
    assign buf_wr  = reg_wr && reg_sel;
    assign stb     = baud_tick && (ctrl_q.fast || pre);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_meta <= 2'b11;
            pre     <= 1'b0;
        end else begin
            rx_meta <= {rx_meta[0], rxd_in};
            if (baud_tick) pre <= ~pre;
        end
    end

    dmsp_shift_eng #(.DW(DW), .DIV(SYNC_DIV)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .active   (!is_uart),
        .tx_req   (buf_wr && !is_uart),
        .tx_byte  (reg_wdata),
        .rx_allow (ctrl_q.rx_on && !ctrl_q.rx_flag),
        .din      (rxd_in),
        .shclk    (sh_clk),
        .dout     (sh_dout),
        .doe      (sh_doe),
        .tx_end   (sh_tx_end),
        .rx_end   (sh_rx_end),
        .rx_byte  (sh_byte)
    );

    dmsp_uart_tx #(.DW(DW), .OVS(OVS)) u_utx (
        .clk    (clk),
        .rst    (rst),
        .active (is_uart),
        .stb    (stb),
        .load   (buf_wr && is_uart),
        .data   (reg_wdata),
        .line   (u_line),
        .done   (u_tx_done)
    );

    dmsp_uart_rx #(.DW(DW), .OVS(OVS)) u_urx (
        .clk    (clk),
        .rst    (rst),
        .active (is_uart && ctrl_q.rx_on),
        .stb    (stb),
        .din    (rx_meta[1]),
        .got    (u_got),
        .byte_o (u_byte)
    );

    assign rx_store = (sh_rx_end || u_got) && !ctrl_q.rx_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            rx_buf_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q       <= ctrl_t'(reg_wdata[7:0]);
                ctrl_q.spare <= '0;
            end
            if (sh_tx_end || u_tx_done)
                ctrl_q.tx_flag <= 1'b1;
            if (rx_store) begin
                ctrl_q.rx_flag <= 1'b1;
                rx_buf_q       <= sh_rx_end ? sh_byte : u_byte;
            end
        end
    end

    assign reg_rdata = reg_sel ? rx_buf_q : DW'(ctrl_q);
    assign txd       = is_uart ? u_line : sh_clk;
    assign rxd_out   = sh_dout;
    assign rxd_oe    = sh_doe;
    assign tx_done   = ctrl_q.tx_flag;
    assign rx_done   = ctrl_q.rx_flag;

endmodule

// File: rtl/dmsp_chk.sv
module dmsp_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_sel,
    input logic          rxd_oe,
    input logic          txd,
    input logic          tx_done,
    input logic          rx_done,
    input logic          is_uart,
    input logic [DW-1:0] rx_buf
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && !reg_sel;

    a_r6_tx_sticky: assert property (@(posedge clk) disable iff (rst)
        tx_done && !ctrl_wr |=> tx_done);

    a_r6_rx_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_done && !ctrl_wr |=> rx_done);

    a_r9_buf_held: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> $stable(rx_buf));

    a_r2_oe_shift_only: assert property (@(posedge clk) disable iff (rst)
        rxd_oe |-> !is_uart);

    a_r2_clock_low_first: assert property (@(posedge clk) disable iff (rst)
        $rose(rxd_oe) |-> !txd);

    a_r2_done_after_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) && !$past(ctrl_wr) && !is_uart |-> $past(rxd_oe));

endmodule

bind dmsp_top dmsp_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel),
    .rxd_oe  (rxd_oe),
    .txd     (txd),
    .tx_done (tx_done),
    .rx_done (rx_done),
    .is_uart (is_uart),
    .rx_buf  (rx_buf_q)
);

// File: tb/sim_dmsp_top.sv
`timescale 1ns/1ps
module sim_dmsp_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rxd_in = 1'b1;
    logic       rxd_out, rxd_oe, txd, tx_done, rx_done;

    int n_run = 0;
    int n_fail = 0;

    dmsp_top u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rxd_in(rxd_in), .rxd_out(rxd_out),
        .rxd_oe(rxd_oe), .txd(txd), .tx_done(tx_done), .rx_done(rx_done)
    );

    always #2.5 clk = ~clk;

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            baud_tick = (c == 3);
            c = (c + 1) % 4;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_run++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        rd(1'b1, v); chk("R1 buffer", v, 8'h00);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 oe", rxd_oe, 1'b0);
    endtask

    // R2 / R6: shift-mode transmit
    task automatic t_shift_tx(input logic [7:0] b);
        logic [7:0] got = 8'h00;
        logic [7:0] v;
        int oe_bad = 0;
        realtime t_prev = 0.0;
        realtime t_now;
        int per_bad = 0;
        wr(1'b0, 8'h00);
        wr(1'b1, b);
        for (int k = 0; k < 8; k++) begin
            @(posedge txd);
            t_now = $realtime;
            if (k > 0 && (t_now - t_prev) != 60.0) per_bad++;
            t_prev = t_now;
            @(negedge clk);
            got[k] = rxd_out;
            if (!rxd_oe) oe_bad++;
        end
        chk("R2 shift tx data", got, b);
        chk("R2 oe during bits", oe_bad, 0);
        chk("R2 bit period 12 clocks", per_bad, 0);
        idle(20);
        chk("R2 oe released", rxd_oe, 1'b0);
        rd(1'b0, v);
        chk("R2 tx_done set", v[6], 1'b1);
        idle(200);
        chk("R6 tx_done sticky", tx_done, 1'b1);
        wr(1'b0, 8'h00);
        chk("R6 cleared by write", tx_done, 1'b0);
    endtask

    // R3 / R10: shift-mode receive
    task automatic t_shift_rx(input logic [7:0] b);
        logic [7:0] v;
        int lows = 0;
        @(negedge clk);
        rxd_in = b[0];
        wr(1'b0, 8'h02);
        for (int k = 1; k < 8; k++) begin
            @(posedge txd);
            @(negedge txd);
            @(negedge clk);
            rxd_in = b[k];
        end
        @(posedge txd);
        idle(10);
        rd(1'b0, v);
        chk("R3 rx_done set", v[7], 1'b1);
        rd(1'b1, v);
        chk("R3 shift rx byte", v, b);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R3 no clock while full", lows, 0);
        wr(1'b1, 8'h5A);
        idle(8 * 12 + 10);
        rd(1'b1, v);
        chk("R10 buffer unchanged by tx", v, b);
        chk("R2 tx after rx done", tx_done, 1'b1);
        wr(1'b0, 8'h00);
        rxd_in = 1'b1;
    endtask

    // R5: one bit time length in UART mode
    task automatic t_rate(input logic fast);
        int bt = fast ? 64 : 128;
        int n = 0;
        wr(1'b0, fast ? 8'h05 : 8'h01);
        fork
            wr(1'b1, 8'hFF);
            begin
                @(negedge txd);
                @(negedge clk);
                while (txd == 1'b0) begin
                    n++;
                    @(negedge clk);
                end
            end
        join
        chk_rng(fast ? "R5 bit time x16" : "R5 bit time x32", n, bt - 8, bt);
        idle(10 * bt);
        wr(1'b0, 8'h01);
    endtask

    // R4 / R11 / R6: UART transmit frame
    task automatic t_uart_tx(input logic [7:0] b, input logic fast);
        int bt = fast ? 64 : 128;
        logic [7:0] got = 8'h00;
        logic startb = 1'b1;
        logic stopb = 1'b0;
        int lows = 0;
        logic [7:0] v;
        wr(1'b0, fast ? 8'h05 : 8'h01);
        fork
            begin
                wr(1'b1, b);
                idle(20);
                wr(1'b1, ~b);
            end
            begin
                @(negedge txd);
                idle(bt / 2);
                startb = txd;
                for (int k = 0; k < 8; k++) begin
                    idle(bt);
                    got[k] = txd;
                end
                idle(bt);
                stopb = txd;
            end
        join
        chk("R4 start bit", startb, 1'b0);
        chk("R4 data bits", got, b);
        chk("R4 stop bit", stopb, 1'b1);
        for (int k = 0; k < 2 * bt; k++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R11 write while busy ignored", lows, 0);
        rd(1'b0, v);
        chk("R6 uart tx_done", v[6], 1'b1);
        wr(1'b0, fast ? 8'h05 : 8'h01);
    endtask

    task automatic send(input logic [7:0] b, input int bt);
        @(negedge clk);
        rxd_in = 1'b0;
        idle(bt);
        for (int k = 0; k < 8; k++) begin
            rxd_in = b[k];
            idle(bt);
        end
        rxd_in = 1'b1;
        idle(bt + 8);
    endtask

    // R7 / R9 / R10 / R5: UART receive
    task automatic t_uart_rx();
        logic [7:0] v;
        wr(1'b0, 8'h07);
        send(8'hC3, 64);
        rd(1'b0, v); chk("R7 rx_done", v[7], 1'b1);
        rd(1'b1, v); chk("R7 rx byte", v, 8'hC3);
        send(8'h18, 64);
        rd(1'b1, v); chk("R9 byte discarded", v, 8'hC3);
        chk("R9 flag still set", rx_done, 1'b1);
        wr(1'b1, 8'h11);
        rd(1'b1, v); chk("R10 uart tx write keeps rx byte", v, 8'hC3);
        idle(12 * 64);
        wr(1'b0, 8'h07);
        send(8'h7E, 64);
        rd(1'b1, v); chk("R7 rx after clear", v, 8'h7E);
        wr(1'b0, 8'h03);
        send(8'h96, 128);
        rd(1'b1, v); chk("R5 rx at x32", v, 8'h96);
        wr(1'b0, 8'h07);
    endtask

    // R8: glitch rejection
    task automatic t_noise();
        logic [7:0] v;
        wr(1'b0, 8'h07);
        @(negedge clk);
        rxd_in = 1'b0;
        idle(12);
        rxd_in = 1'b1;
        idle(3 * 64);
        rd(1'b0, v);
        chk("R8 glitch ignored", v[7], 1'b0);
        send(8'h42, 64);
        rd(1'b1, v);
        chk("R8 frame after glitch", v, 8'h42);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_shift_tx(8'hA5);
        t_shift_tx(8'h3C);
        t_shift_rx(8'h69);
        t_rate(1'b1);
        t_rate(1'b0);
        t_uart_tx(8'hB4, 1'b1);
        t_uart_tx(8'h2D, 1'b0);
        t_uart_rx();
        t_noise();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule